// File: doc/BRIEF.md
# Program-Enable Guard and Timed Write Cycle Controller

This block sits behind the serial instruction decoder of a small word-organised non-volatile store. It owns the program-enable state and gates every array-modifying request with it. An accepted modifying request is held until chip select falls, and the fall starts a timed write cycle. The cycle drives the array's write port: one word for single-word requests, or every word in turn for whole-array requests. While the cycle runs, new requests and serial activity have no effect.

When chip select is raised after a cycle has been launched, the block drives the serial data output as a busy/ready flag, low while busy and high when done. The host can repeat this check as often as it likes. A start bit seen while the flag shows ready ends the check, and the output returns to high impedance. A low-supply indication closes the program-enable state, drops any request still waiting for chip select, and aborts a cycle in progress. Chip select, serial clock, serial data and the low-supply input pass through a parameterised synchroniser. Decoded requests come in already aligned to the system clock.

Top module: `nwc_write_ctrl`

## Requirements
- R1: A request with code 5 sets the program-enable state and code 6 clears it. A modifying request (codes 1 to 4) that arrives while the state is clear changes no array word and launches no cycle. Reset leaves the state clear.
- R2: While the low-supply input is high, the program-enable state is cleared and an accepted request still waiting for chip select is dropped, so the following chip select fall writes nothing.
- R3: A cycle starts when the synchronised chip select is seen falling while an accepted modifying request waits. The cycle stays busy for exactly WR_CYCLES system clocks.
- R4: Code 1 (single write) replaces the addressed word with the request data, whatever its old content.
- R5: Code 2 (single erase) sets the addressed word to all ones.
- R6: Code 3 (fill) writes the request data to every word exactly once, whatever address was sent.
- R7: Code 4 (wipe) sets every word to all ones.
- R8: While a cycle is busy, new requests are ignored. A request sent during the cycle produces no array write, even after a later chip select fall.
- R9: After a launch, with chip select high, the output enable is on and the data output is low while busy and high once the cycle is done. Lowering and raising chip select repeats the report.
- R10: A start bit (serial data high on a rising serial clock edge with chip select high) while the report shows ready disables the output on the following clock. The output stays high impedance until the next launch. A start bit during a busy cycle is ignored.
- R11: A low-supply indication during a cycle stops all further array writes and ends the busy state, so the report then shows ready.
- R12: The output enable is off whenever chip select is low, and stays off after reset until the first launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, used as power-on |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| lowv_i | input | 1 | Low-supply indication, active high |
| req_valid_i | input | 1 | One-clock strobe for a decoded request |
| req_op_i | input | 3 | Request code: 1 write, 2 erase, 3 fill, 4 wipe, 5 enable, 6 disable |
| req_addr_i | input | ADDR_W | Word address of the request |
| req_data_i | input | DATA_W | Data word of the request |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Serial data out enable (low means high impedance) |

## Verification
The bench builds the block with its default 9-bit address and 16-bit word and a two-stage synchroniser, but with WR_CYCLES set to 600. That keeps a whole-array cycle only slightly longer than the 512-word sweep, so dozens of fills and wipes fit in a short run. With this length the busy-to-ready edge can be checked at an exact clock. A low-supply pulse can land in the middle of a sweep, and requests and start bits can be sent into a running cycle.

// File: rtl/nwc_pkg.sv
package nwc_pkg;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_WRITE = 3'd1,
      OP_ERASE = 3'd2,
      OP_FILL  = 3'd3,
      OP_WIPE  = 3'd4,
      OP_WEN   = 3'd5,
      OP_WDS   = 3'd6,
      OP_RSVD  = 3'd7
   } nwc_op_t;

   function automatic logic op_modifies(input nwc_op_t op);
      return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_FILL) || (op == OP_WIPE);
   endfunction

   function automatic logic op_whole(input nwc_op_t op);
      return (op == OP_FILL) || (op == OP_WIPE);
   endfunction

   function automatic logic op_ones(input nwc_op_t op);
      return (op == OP_ERASE) || (op == OP_WIPE);
   endfunction

endpackage

// File: rtl/nwc_insync.sv
module nwc_insync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg <= '0;
            end else begin
               stg[0] <= d_i;
               for (int i = 1; i < STAGES; i++) begin
                  stg[i] <= stg[i-1];
               end
            end
         end
         assign q_o = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/nwc_guard.sv
module nwc_guard import nwc_pkg::*; #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              lowv,
   input  logic              busy,
   input  logic              req_valid,
   input  nwc_op_t           req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              launch,
   output logic              pend_whole,
   output logic [ADDR_W-1:0] pend_addr,
   output logic [DATA_W-1:0] pend_word
);

   logic    wel;
   logic    pend;
   logic    cs_q;
   nwc_op_t pend_op;
   logic [DATA_W-1:0] pend_data;

   assign launch     = cs_q & ~cs & pend & ~busy & ~lowv;
   assign pend_whole = op_whole(pend_op);
   assign pend_word  = op_ones(pend_op) ? {DATA_W{1'b1}} : pend_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel       <= 1'b0;
         pend      <= 1'b0;
         cs_q      <= 1'b0;
         pend_op   <= OP_NONE;
         pend_addr <= '0;
         pend_data <= '0;
      end else begin
         cs_q <= cs;
         if (lowv) begin
            wel  <= 1'b0;
            pend <= 1'b0;
         end else if (launch) begin
            pend <= 1'b0;
         end else if (req_valid && !busy) begin
            if (req_op == OP_WEN) begin
               wel <= 1'b1;
            end else if (req_op == OP_WDS) begin
               wel <= 1'b0;
            end else if (op_modifies(req_op) && wel) begin
               pend      <= 1'b1;
               pend_op   <= req_op;
               pend_addr <= req_addr;
               pend_data <= req_data;
            end
         end
      end
   end

endmodule

// File: rtl/nwc_cycle.sv
module nwc_cycle #(
   parameter int ADDR_W    = 9,
   parameter int DATA_W    = 16,
   parameter int WR_CYCLES = 20000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lowv,
   input  logic              launch,
   input  logic              whole,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] word,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int CNT_W = $clog2(WR_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

   logic [CNT_W-1:0]  cnt;
   logic              whole_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] word_q;
   logic              in_sweep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cnt     <= '0;
         whole_q <= 1'b0;
         addr_q  <= '0;
         word_q  <= '0;
      end else if (lowv) begin
         busy <= 1'b0;
      end else if (launch) begin
         busy    <= 1'b1;
         cnt     <= '0;
         whole_q <= whole;
         addr_q  <= addr;
         word_q  <= word;
      end else if (busy) begin
         if (cnt == LAST) begin
            busy <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign in_sweep  = whole_q ? (32'(cnt) < DEPTH) : (cnt == '0);
   assign mem_we    = busy & ~lowv & in_sweep;
   assign mem_addr  = whole_q ? cnt[ADDR_W-1:0] : addr_q;
   assign mem_wdata = word_q;

endmodule

// File: rtl/nwc_verify.sv
module nwc_verify (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sk,
   input  logic di,
   input  logic busy,
   input  logic launch,
   output logic do_o,
   output logic do_oe
);

   logic sk_q;
   logic armed;
   logic start_seen;

   assign start_seen = cs & sk & ~sk_q & di & armed & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sk_q  <= 1'b0;
         armed <= 1'b0;
      end else begin
         sk_q <= sk;
         if (launch) begin
            armed <= 1'b1;
         end else if (start_seen) begin
            armed <= 1'b0;
         end
      end
   end

   assign do_oe = cs & armed;
   assign do_o  = do_oe & ~busy;

endmodule

// File: rtl/nwc_write_ctrl.sv
module nwc_write_ctrl import nwc_pkg::*; #(
   parameter int ADDR_W      = 9,
   parameter int DATA_W      = 16,
   parameter int WR_CYCLES   = 20000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              sk_i,
   input  logic              di_i,
   input  logic              lowv_i,
   input  logic              req_valid_i,
   input  logic [2:0]        req_op_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_data_i,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              do_o,
   output logic              do_oe_o
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (WR_CYCLES < DEPTH) begin : g_bad_len
         $error("WR_CYCLES must cover one write per word of the array");
      end
      if (SYNC_STAGES < 0 || ADDR_W < 1 || DATA_W < 1) begin : g_bad_geom
         $error("bad geometry or synchroniser depth");
      end
   endgenerate

   logic [3:0]        sync_q;
   logic              cs_s, sk_s, di_s, lowv_s;
   logic              busy;
   logic              launch;
   logic              pend_whole;
   logic [ADDR_W-1:0] pend_addr;
   logic [DATA_W-1:0] pend_word;

   nwc_insync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({lowv_i, di_i, sk_i, cs_i}),
      .q_o   (sync_q)
   );
   assign {lowv_s, di_s, sk_s, cs_s} = sync_q;

   nwc_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs         (cs_s),
      .lowv       (lowv_s),
      .busy       (busy),
      .req_valid  (req_valid_i),
      .req_op     (nwc_op_t'(req_op_i)),
      .req_addr   (req_addr_i),
      .req_data   (req_data_i),
      .launch     (launch),
      .pend_whole (pend_whole),
      .pend_addr  (pend_addr),
      .pend_word  (pend_word)
   );

   nwc_cycle #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CYCLES(WR_CYCLES)) u_cycle (
      .clk       (clk),
      .rst_n     (rst_n),
      .lowv      (lowv_s),
      .launch    (launch),
      .whole     (pend_whole),
      .addr      (pend_addr),
      .word      (pend_word),
      .busy      (busy),
      .mem_we    (mem_we_o),
      .mem_addr  (mem_addr_o),
      .mem_wdata (mem_wdata_o)
   );

   nwc_verify u_verify (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs     (cs_s),
      .sk     (sk_s),
      .di     (di_s),
      .busy   (busy),
      .launch (launch),
      .do_o   (do_o),
      .do_oe  (do_oe_o)
   );

endmodule

// File: rtl/nwc_write_ctrl_chk.sv
module nwc_write_ctrl_chk #(
   parameter int WR_CYCLES = 20000
) (
   input logic clk,
   input logic rst_n,
   input logic cs_s,
   input logic lowv_s,
   input logic busy,
   input logic mem_we,
   input logic do_o,
   input logic do_oe
);

   localparam int RUN_W = $clog2(WR_CYCLES + 2);
   logic [RUN_W-1:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_run <= '0;
      end else if (busy) begin
         if (32'(busy_run) <= WR_CYCLES) busy_run <= busy_run + 1'b1;
      end else begin
         busy_run <= '0;
      end
   end

   // R3: a cycle never outlasts its configured length
   p_cycle_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(busy_run) <= WR_CYCLES);

   // R2: no cycle starts while the supply is flagged low
   p_no_start_lowv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(lowv_s));

   // R11: low supply blocks the array port
   p_no_write_lowv_r11: assert property (@(posedge clk) disable iff (!rst_n)
      lowv_s |-> !mem_we);

   // R11: after low supply the cycle is over
   p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
      lowv_s |=> !busy);

   // R9: the report reads low while busy
   p_busy_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (do_oe && busy) |-> !do_o);

   // R12: no drive while chip select is low
   p_hiz_cs_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |-> !do_oe);

   // R8: array writes only inside a cycle
   p_write_in_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

endmodule

bind nwc_write_ctrl nwc_write_ctrl_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs_s   (cs_s),
   .lowv_s (lowv_s),
   .busy   (busy),
   .mem_we (mem_we_o),
   .do_o   (do_o),
   .do_oe  (do_oe_o)
);

// File: tb/nwc_write_ctrl_bench.sv
`timescale 1ns/1ps
module nwc_write_ctrl_bench;

   localparam int AW    = 9;
   localparam int DW    = 16;
   localparam int DEPTH = 1 << AW;
   localparam int WRC   = 600;

   localparam logic [2:0] C_WRITE = 3'd1, C_ERASE = 3'd2, C_FILL = 3'd3,
                          C_WIPE  = 3'd4, C_WEN   = 3'd5, C_WDS   = 3'd6;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cs, sk, di, lowv;
   logic          req_valid;
   logic [2:0]    req_op;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_data;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          do_v, do_oe;

   int nchk  = 0;
   int nfail = 0;
   int we_cnt = 0;
   int cyc = 0;
   bit exp_wel = 1'b0;

   logic [DW-1:0] shadow  [DEPTH];
   logic [DW-1:0] exp_mem [DEPTH];

   always #2.5 clk = ~clk;

   nwc_write_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WR_CYCLES(WRC), .SYNC_STAGES(2)) u_nwc_write_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .lowv_i(lowv),
      .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data),
      .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
      .do_o(do_v), .do_oe_o(do_oe));

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) shadow[i] <= 16'hFFFF;
      end else if (mem_we) begin
         shadow[mem_addr] <= mem_wdata;
         we_cnt <= we_cnt + 1;
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         nfail++;
         $display("FAIL R3 watchdog expired actual=%0d expected<=150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int mismatches();
      int m = 0;
      for (int i = 0; i < DEPTH; i++) if (shadow[i] !== exp_mem[i]) m++;
      return m;
   endfunction

   task automatic start_bit();
      di = 1'b1; sk = 1'b1; tick(2);
      sk = 1'b0; di = 1'b0; tick(2);
   endtask

   task automatic pulse_req(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
      req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
      tick(1);
      req_valid = 1'b0;
      tick(1);
   endtask

   // raise CS, send a start bit and the decoded request; CS stays high
   task automatic open_instr(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
      cs = 1'b1; tick(4);
      start_bit();
      pulse_req(op, a, d);
   endtask

   function automatic void model(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
      case (op)
         C_WEN: exp_wel = 1'b1;
         C_WDS: exp_wel = 1'b0;
         C_WRITE: if (exp_wel) exp_mem[a] = d;
         C_ERASE: if (exp_wel) exp_mem[a] = 16'hFFFF;
         C_FILL:  if (exp_wel) for (int i = 0; i < DEPTH; i++) exp_mem[i] = d;
         C_WIPE:  if (exp_wel) for (int i = 0; i < DEPTH; i++) exp_mem[i] = 16'hFFFF;
         default: ;
      endcase
   endfunction

   task automatic wait_ready(input string req);
      int n = 0;
      cs = 1'b1;
      while (!(do_oe && do_v) && n < WRC + 60) begin tick(1); n++; end
      check(do_oe && do_v, req, {do_oe, do_v}, 3);
   endtask

   // full instruction, closes with CS low; launched cycles are waited out and disarmed
   task automatic run_instr(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
      bit launches;
      launches = exp_wel && (op inside {C_WRITE, C_ERASE, C_FILL, C_WIPE});
      model(op, a, d);
      open_instr(op, a, d);
      cs = 1'b0; tick(4);
      if (launches) begin
         wait_ready("R9 ready report after cycle");
         start_bit();
         cs = 1'b0; tick(3);
      end
   endtask

   initial begin
      int w0, seed;
      seed = $urandom(32'd9137);
      rst_n = 1'b0; cs = 0; sk = 0; di = 0; lowv = 0;
      req_valid = 0; req_op = 0; req_addr = 0; req_data = 0;
      for (int i = 0; i < DEPTH; i++) exp_mem[i] = 16'hFFFF;
      tick(5);
      rst_n = 1'b1;
      tick(3);

      // reset state
      check(do_oe == 1'b0, "R12 output off after reset", do_oe, 0);
      cs = 1'b1; tick(6);
      check(do_oe == 1'b0, "R12 no report before first launch", do_oe, 0);
      cs = 1'b0; tick(4);
      check(do_oe == 1'b0, "R12 output off with CS low", do_oe, 0);

      // disabled after reset: write ignored
      w0 = we_cnt;
      run_instr(C_WRITE, 9'd5, 16'h1234);
      tick(10);
      check(we_cnt == w0, "R1 write ignored while disabled", we_cnt - w0, 0);
      check(shadow[5] == 16'hFFFF, "R1 word kept while disabled", shadow[5], 16'hFFFF);

      // enable, then timed single write
      run_instr(C_WEN, 0, 0);
      model(C_WRITE, 9'd5, 16'h1234);
      open_instr(C_WRITE, 9'd5, 16'h1234);
      cs = 1'b0; tick(2);
      cs = 1'b1; tick(WRC);
      check(do_oe && !do_v, "R3 busy on last cycle", {do_oe, do_v}, 2);
      tick(1);
      check(do_oe && do_v, "R3 ready right after cycle", {do_oe, do_v}, 3);
      check(shadow[5] == 16'h1234, "R4 word written", shadow[5], 16'h1234);
      cs = 1'b0; tick(4);
      check(do_oe == 1'b0, "R12 off between reports", do_oe, 0);
      cs = 1'b1; tick(4);
      check(do_oe && do_v, "R9 report repeats", {do_oe, do_v}, 3);
      di = 1'b1; sk = 1'b1; tick(2);
      check(do_oe == 1'b1, "R10 still driving before start bit lands", do_oe, 1);
      tick(1);
      check(do_oe == 1'b0, "R10 high impedance after start bit", do_oe, 0);
      sk = 1'b0; di = 1'b0; tick(2);
      cs = 1'b0; tick(3);

      // overwrite without erase, then erase
      run_instr(C_WRITE, 9'd5, 16'h0F0F);
      check(shadow[5] == 16'h0F0F, "R4 overwrite without erase", shadow[5], 16'h0F0F);
      run_instr(C_ERASE, 9'd5, 16'h0000);
      check(shadow[5] == 16'hFFFF, "R5 erase gives all ones", shadow[5], 16'hFFFF);

      // fill and wipe
      w0 = we_cnt;
      run_instr(C_FILL, 9'd77, 16'hA5A5);
      check(we_cnt - w0 == DEPTH, "R6 one write per word", we_cnt - w0, DEPTH);
      check(mismatches() == 0, "R6 every word filled", mismatches(), 0);
      run_instr(C_WIPE, 9'd3, 16'h0000);
      check(mismatches() == 0, "R7 every word all ones", mismatches(), 0);

      // request and start bit during busy
      model(C_WRITE, 9'd9, 16'h1111);
      open_instr(C_WRITE, 9'd9, 16'h1111);
      cs = 1'b0; tick(2);
      cs = 1'b1; tick(20);
      w0 = we_cnt;
      start_bit();
      pulse_req(C_WRITE, 9'd10, 16'h2222);
      tick(2);
      check(do_oe && !do_v, "R10 start bit ignored while busy", {do_oe, do_v}, 2);
      wait_ready("R9 ready after busy-time traffic");
      start_bit();
      cs = 1'b0; tick(4);
      cs = 1'b1; tick(4);
      cs = 1'b0; tick(WRC / 4);
      check(we_cnt == w0, "R8 request during cycle dropped", we_cnt - w0, 0);
      check(shadow[10] == 16'hFFFF, "R8 word untouched", shadow[10], 16'hFFFF);
      check(shadow[9] == 16'h1111, "R4 write before busy traffic", shadow[9], 16'h1111);

      // low supply clears enable
      lowv = 1'b1; tick(4); lowv = 1'b0; tick(4);
      exp_wel = 1'b0;
      w0 = we_cnt;
      run_instr(C_WRITE, 9'd20, 16'h3333);
      tick(10);
      check(we_cnt == w0, "R2 enable cleared by low supply", we_cnt - w0, 0);

      // low supply drops a waiting request
      run_instr(C_WEN, 0, 0);
      open_instr(C_WRITE, 9'd21, 16'h4444);
      lowv = 1'b1; tick(4); lowv = 1'b0; tick(4);
      exp_wel = 1'b0;
      cs = 1'b0; tick(4);
      cs = 1'b1; tick(6);
      check(do_oe == 1'b0, "R2 no cycle after dropped request", do_oe, 0);
      cs = 1'b0; tick(WRC / 4);
      check(we_cnt == w0 && shadow[21] == 16'hFFFF, "R2 waiting request dropped", we_cnt - w0, 0);

      // low supply mid-sweep
      run_instr(C_WEN, 0, 0);
      w0 = we_cnt;
      open_instr(C_FILL, 9'd0, 16'h5A5A);
      cs = 1'b0; tick(2);
      cs = 1'b1; tick(100);
      lowv = 1'b1; tick(4); lowv = 1'b0; tick(4);
      exp_wel = 1'b0;
      begin
         int w1;
         w1 = we_cnt;
         tick(WRC);
         check(we_cnt == w1, "R11 no writes after abort", we_cnt - w1, 0);
         check(we_cnt - w0 > 0 && we_cnt - w0 < DEPTH, "R11 sweep cut short", we_cnt - w0, 100);
      end
      check(do_oe && do_v, "R11 report shows ready after abort", {do_oe, do_v}, 3);
      start_bit();
      cs = 1'b0; tick(4);
      for (int i = 0; i < DEPTH; i++) exp_mem[i] = shadow[i];

      // random mix
      for (int k = 0; k < 40; k++) begin
         logic [2:0]    op;
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         int r;
         r = $urandom % 16;
         a = AW'($urandom);
         d = DW'($urandom);
         case (r)
            0:       op = C_WDS;
            1, 2, 3: op = C_WEN;
            9, 10:   op = C_ERASE;
            11:      op = C_FILL;
            12:      op = C_WIPE;
            default: op = C_WRITE;
         endcase
         run_instr(op, a, d);
         check(mismatches() == 0, "R4 R5 R6 R7 R1 random sequence", mismatches(), 0);
      end

      summary();
      $finish;
   end

endmodule